// File: doc/BRIEF.md
# Link Rate Negotiation Controller

This block is the device-side state machine that settles the serial link rate once out-of-band signalling has finished. On a start request it begins at a configured highest generation and transmits the alignment primitive for a fixed window. It watches a per-DWORD decode of the received primitive, together with the rate at which that DWORD was recovered, for alignment primitives coming back from the host.

The host counts as present after a run of consecutive alignment DWORDs received at the generation currently being transmitted. The controller then switches to the sync primitive and holds the link-up flag. If the window closes with no host found, the controller moves to a reduce-speed state and requests the next lower generation from the transmit PLL. It stays there for a minimum dwell and until the PLL acknowledges lock, then opens a fresh window at the new rate. If the window also closes at the lowest generation, the controller reports failure and goes idle until the next start request.

Top module: `link_rate_negotiator`

## Requirements
- R1: While reset is asserted and after it is released, the controller is idle: tx_prim_o is 0 (idle code), rate_req_o equals GEN_MAX, and link_up_o and neg_fail_o are 0.
- R2: During negotiation at any generation, tx_prim_o carries the alignment code 1 for exactly WINDOW_CYC consecutive cycles, unless the host is found first.
- R3: A received DWORD counts toward host detection only when rx_prim_i is the alignment code 1 and rx_rate_i equals the current rate_req_o.
- R4: The host is declared present after DETECT_LEN consecutive counting DWORDs; any other DWORD resets the run to zero.
- R5: The cycle after the last detecting DWORD is sampled, tx_prim_o becomes the sync code 2 and link_up_o becomes 1, and both hold until reset.
- R6: When a window closes without detection at a generation above 1, rate_req_o drops by exactly one and tx_prim_o is 0 in the reduce-speed state; rate_req_o never leaves the range 1 to GEN_MAX.
- R7: The reduce-speed state lasts at least RELOCK_MIN_CYC cycles and is left only on a clock edge at which pll_lock_i is 1.
- R8: After relock, a new full window of WINDOW_CYC alignment cycles runs at the lower generation.
- R9: When the window closes at generation 1, neg_fail_o becomes 1, rate_req_o returns to GEN_MAX, and the controller goes idle; the next start clears neg_fail_o. neg_fail_o and link_up_o are never 1 together.
- R10: start_i acts only in the idle state; a start request while the link is up leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DWORD-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin negotiation (acts in idle only) |
| rx_prim_i | input | 2 | Received primitive decode: 1 alignment, other values any other DWORD |
| rx_rate_i | input | 2 | Generation at which the received DWORD was recovered |
| pll_lock_i | input | 1 | Transmit PLL lock acknowledge |
| tx_prim_o | output | 2 | Transmit primitive select: 0 idle, 1 alignment, 2 sync |
| rate_req_o | output | 2 | Requested generation (3 highest, 1 lowest) |
| link_up_o | output | 1 | Host detected, link established |
| neg_fail_o | output | 1 | Negotiation failed at the lowest generation |

## Verification
The bench builds the controller with a 40-cycle window, a 6-cycle minimum relock dwell, an 8-DWORD detection run and a top generation of 3. These short windows put a full descent from generation 3 to failure within a few hundred cycles, so every window close, every relock wait and the fail-then-restart path are reached in one run. The short dwell also lets the bench hold lock low well past the minimum and show that the dwell stretches.

// File: rtl/lrn_pkg.sv
package lrn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_REDUCE = 2'd2,
    ST_UP     = 2'd3
  } lrn_state_e;

  localparam logic [1:0] PRIM_NONE  = 2'd0;
  localparam logic [1:0] PRIM_ALIGN = 2'd1;
  localparam logic [1:0] PRIM_SYNC  = 2'd2;
endpackage

// File: rtl/lrn_cycle_timer.sv
module lrn_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lrn_align_detect.sv
module lrn_align_detect #(
  parameter int NEED = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hit_i,
  output logic found_o
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);

  logic [CW-1:0] cnt_q;

  assign found_o = run_i && hit_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || !hit_i) cnt_q <= '0;   // run broken: start over
    else if (!found_o)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_rate_negotiator.sv
module link_rate_negotiator
  import lrn_pkg::*;
#(
  parameter int GEN_MAX        = 3,
  parameter int WINDOW_CYC     = 8190,
  parameter int RELOCK_MIN_CYC = 150,
  parameter int DETECT_LEN     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] rx_prim_i,
  input  logic [1:0] rx_rate_i,
  input  logic       pll_lock_i,
  output logic [1:0] tx_prim_o,
  output logic [1:0] rate_req_o,
  output logic       link_up_o,
  output logic       neg_fail_o
);
  localparam logic [1:0] GEN_TOP = 2'(GEN_MAX);
  localparam logic [1:0] GEN_LOW = 2'd1;

  lrn_state_e state_q, state_d;
  logic [1:0] gen_q, gen_d;
  logic       fail_q, fail_d;

  logic win_run, win_done, rs_run, rs_done, host_hit, host_found;

  assign win_run  = (state_q == ST_ALIGN);
  assign rs_run   = (state_q == ST_REDUCE);
  assign host_hit = (rx_prim_i == PRIM_ALIGN) && (rx_rate_i == gen_q);

  lrn_cycle_timer #(.LIMIT(WINDOW_CYC)) u_win_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(win_run), .done_o(win_done)
  );

  lrn_cycle_timer #(.LIMIT(RELOCK_MIN_CYC)) u_rs_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(rs_run), .done_o(rs_done)
  );

  lrn_align_detect #(.NEED(DETECT_LEN)) u_det (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(win_run), .hit_i(host_hit),
    .found_o(host_found)
  );

  always_comb begin
    state_d = state_q;
    gen_d   = gen_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ALIGN;
          gen_d   = GEN_TOP;
          fail_d  = 1'b0;
        end
      end
      ST_ALIGN: begin
        // detection wins over expiry on the same cycle
        if (host_found) begin
          state_d = ST_UP;
        end else if (win_done) begin
          if (gen_q == GEN_LOW) begin
            state_d = ST_IDLE;
            gen_d   = GEN_TOP;
            fail_d  = 1'b1;
          end else begin
            state_d = ST_REDUCE;
            gen_d   = gen_q - 2'd1;
          end
        end
      end
      ST_REDUCE: begin
        if (rs_done && pll_lock_i) state_d = ST_ALIGN;
      end
      ST_UP: state_d = ST_UP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gen_q   <= GEN_TOP;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gen_q   <= gen_d;
      fail_q  <= fail_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ALIGN: tx_prim_o = PRIM_ALIGN;
      ST_UP:    tx_prim_o = PRIM_SYNC;
      default:  tx_prim_o = PRIM_NONE;
    endcase
  end

  assign rate_req_o = gen_q;
  assign link_up_o  = (state_q == ST_UP);
  assign neg_fail_o = fail_q;
endmodule

// File: rtl/lrn_checker.sv
module lrn_checker
  import lrn_pkg::*;
#(
  parameter int GEN_MAX = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] rx_prim_i,
  input logic [1:0] rx_rate_i,
  input logic       pll_lock_i,
  input logic [1:0] tx_prim_o,
  input logic [1:0] rate_req_o,
  input logic       link_up_o,
  input logic       neg_fail_o,
  input lrn_state_e state_i
);
  p_up_on_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> $past(rx_prim_i == PRIM_ALIGN && rx_rate_i == rate_req_o));

  p_link_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |=> (link_up_o && tx_prim_o == PRIM_SYNC));

  p_step_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_req_o < $past(rate_req_o)) |-> (int'($past(rate_req_o)) - int'(rate_req_o) == 1));

  p_rate_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rate_req_o) >= 1) && (int'(rate_req_o) <= GEN_MAX));

  p_exit_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_REDUCE && state_i == ST_ALIGN) |-> $past(pll_lock_i));

  p_fail_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_up_o && neg_fail_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !start_i) |=> (state_i == ST_IDLE && tx_prim_o == PRIM_NONE));
endmodule

bind link_rate_negotiator lrn_checker #(.GEN_MAX(GEN_MAX)) u_lrn_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rx_prim_i (rx_prim_i),
  .rx_rate_i (rx_rate_i),
  .pll_lock_i(pll_lock_i),
  .tx_prim_o (tx_prim_o),
  .rate_req_o(rate_req_o),
  .link_up_o (link_up_o),
  .neg_fail_o(neg_fail_o),
  .state_i   (state_q)
);

// File: tb/link_rate_negotiator_tb_top.sv
module link_rate_negotiator_tb_top;
  localparam int GMAX = 3;
  localparam int W    = 40;
  localparam int RMIN = 6;
  localparam int DL   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] rx_prim = 2'd0;
  logic [1:0] rx_rate = 2'd0;
  logic       lock = 1'b0;
  logic [1:0] tx_prim, rate_req;
  logic       link_up, neg_fail;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_rate_negotiator #(
    .GEN_MAX(GMAX), .WINDOW_CYC(W), .RELOCK_MIN_CYC(RMIN), .DETECT_LEN(DL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_prim_i(rx_prim),
    .rx_rate_i(rx_rate), .pll_lock_i(lock), .tx_prim_o(tx_prim),
    .rate_req_o(rate_req), .link_up_o(link_up), .neg_fail_o(neg_fail)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 aligning, 2 reducing, 3 up
  int m_st, m_gen, m_win, m_det, m_rs, m_fail;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_gen = GMAX; m_win = 0; m_det = 0; m_rs = 0; m_fail = 0;
    end else begin
      case (m_st)
        0: if (start) begin
             m_st = 1; m_gen = GMAX; m_win = 0; m_det = 0; m_fail = 0;
           end
        1: begin
             if (rx_prim == 2'd1 && int'(rx_rate) == m_gen) m_det++;
             else m_det = 0;
             if (m_det == DL) m_st = 3;
             else if (m_win == W - 1) begin
               if (m_gen == 1) begin m_fail = 1; m_st = 0; m_gen = GMAX; end
               else begin m_gen--; m_st = 2; m_rs = 0; end
             end else m_win++;
           end
        2: if (m_rs >= RMIN - 1 && lock) begin
             m_st = 1; m_win = 0; m_det = 0;
           end else m_rs++;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 tx_prim", int'(tx_prim), (m_st == 1) ? 1 : (m_st == 3) ? 2 : 0);
      chk("R6 rate_req", int'(rate_req), m_gen);
      chk("R5 link_up", int'(link_up), (m_st == 3) ? 1 : 0);
      chk("R9 neg_fail", int'(neg_fail), m_fail);
    end
  end

  task automatic step(input logic [1:0] p, input logic [1:0] r, input logic s = 1'b0);
    @(negedge clk);
    rx_prim = p; rx_rate = r; start = s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; rx_prim = 2'd0; rx_rate = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_tx(input logic [1:0] v, input logic [1:0] p,
                          input logic [1:0] r, output int n);
    n = 0;
    while (tx_prim == v && n < 1000) begin
      n++;
      step(p, r);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 tx_prim in reset", int'(tx_prim), 0);
    chk("R1 rate_req in reset", int'(rate_req), GMAX);
    chk("R1 link_up in reset", int'(link_up), 0);
    chk("R1 neg_fail in reset", int'(neg_fail), 0);
    rst_n = 1'b1;
    repeat (3) step(2'd1, 2'd3);
    chk("R1 idle after release", int'(tx_prim), 0);

    // quick detection at top generation
    step(2'd0, 2'd0, 1'b1);
    repeat (DL) step(2'd1, 2'd3);
    step(2'd0, 2'd0);
    chk("R5 link up after run", int'(link_up), 1);
    chk("R5 sync sent", int'(tx_prim), 2);
    step(2'd0, 2'd0, 1'b1);
    step(2'd0, 2'd0);
    step(2'd0, 2'd0);
    chk("R10 start ignored when up", int'(link_up), 1);
    chk("R10 rate unchanged", int'(rate_req), GMAX);

    // broken run restarts the count
    do_reset();
    step(2'd0, 2'd0, 1'b1);
    repeat (DL - 1) step(2'd1, 2'd3);
    step(2'd2, 2'd3);
    step(2'd1, 2'd3);
    step(2'd0, 2'd0);
    chk("R4 broken run no link", int'(link_up), 0);
    repeat (DL) step(2'd1, 2'd3);
    step(2'd0, 2'd0);
    chk("R4 full run links", int'(link_up), 1);

    // wrong-rate alignment ignored, early lock, link at gen 2
    do_reset();
    lock = 1'b1;
    step(2'd0, 2'd0, 1'b1);
    step(2'd1, 2'd2);
    count_tx(2'd1, 2'd1, 2'd2, n);
    chk("R3 wrong rate ignored, window length", n, W);
    chk("R6 stepped to gen 2", int'(rate_req), 2);
    count_tx(2'd0, 2'd0, 2'd0, n);
    chk("R7 minimum dwell", n, RMIN);
    repeat (DL) step(2'd1, 2'd2);
    step(2'd0, 2'd0);
    chk("R8 link at lower gen", int'(link_up), 1);
    chk("R8 rate kept", int'(rate_req), 2);

    // no host: late lock, full descent, fail, restart
    do_reset();
    lock = 1'b0;
    step(2'd0, 2'd0, 1'b1);
    step(2'd0, 2'd0);
    count_tx(2'd1, 2'd0, 2'd0, n);
    chk("R2 window at gen 3", n, W);
    repeat (20) step(2'd0, 2'd0);
    chk("R7 held while unlocked", int'(tx_prim), 0);
    lock = 1'b1;
    step(2'd0, 2'd0);
    chk("R7 leaves on lock", int'(tx_prim), 1);
    count_tx(2'd1, 2'd0, 2'd0, n);
    chk("R8 fresh window at gen 2", n, W);
    count_tx(2'd0, 2'd0, 2'd0, n);
    chk("R7 dwell with lock high", n, RMIN);
    chk("R6 stepped to gen 1", int'(rate_req), 1);
    count_tx(2'd1, 2'd0, 2'd0, n);
    chk("R8 fresh window at gen 1", n, W);
    chk("R9 fail raised", int'(neg_fail), 1);
    chk("R9 rate back to max", int'(rate_req), GMAX);
    step(2'd0, 2'd0, 1'b1);
    step(2'd0, 2'd0);
    chk("R9 fail cleared by start", int'(neg_fail), 0);
    chk("R9 restart aligns", int'(tx_prim), 1);

    repeat (4) step(2'd0, 2'd0);
    finish_run();
  end
endmodule